// File: doc/BRIEF.md
# Compare-and-Shift Execution Unit

This unit executes a small family of compare-then-shift instructions against a sixteen-entry data register file. One instruction word arrives per cycle together with a valid strobe. The unit decodes it and picks the first operand from a register. The second operand comes either from a second register or from a 9-bit immediate, depending on the instruction format. The unit then compares the two with a signed or an unsigned less-than. It does not write that single result bit as a boolean. It shifts the destination register left by one place and drops the result into bit 0, so repeated instructions on the same destination build up a bit-vector history of comparisons.

Words that match none of the four legal encodings change nothing and raise a one-cycle illegal-instruction pulse. A combinational debug port reads any register. The status flags are visible at the ports, but these instructions never alter them.

Top module: `cmp_shift_unit`

## Requirements
- R1: After a legal instruction with destination index c, register c holds its previous bits 30:0 in bits 31:1 and the compare bit in bit 0. Its previous bit 31 is lost.
- R2: The signed variant sets the compare bit when operand A is less than operand B, both read as two's-complement values. Equal operands give 0.
- R3: The unsigned variant sets the compare bit when operand A is less than operand B, both read as unsigned values.
- R4: In the immediate format, the 9-bit immediate in bits 20:12 becomes operand B. It is sign-extended for the signed variant and zero-extended for the unsigned one.
- R5: Decoding uses these fields:
  - Immediate format: primary opcode 0x8B in bits 7:0 and secondary opcode in bits 27:21 (7 bits).
  - Register format: primary opcode 0x0B in bits 7:0, secondary opcode in bits 27:20 (8 bits), and register B index in bits 15:12. Bits 19:16 are ignored.
  - Both formats: register A index in bits 11:8 and destination index in bits 31:28.
  - Secondary opcode 0x39 selects signed and 0x3A selects unsigned.
- R6: The unit reads its operands before it writes. When the destination is also an operand, the compare uses the old contents.
- R7: A valid word that matches no legal encoding leaves every register unchanged. It sets `illegal_o` high for the one cycle after the edge that accepted it.
- R8: While `instr_valid` is low, no register changes and `illegal_o` stays low.
- R9: `flags_o` (five status flags) never changes after reset, whatever instructions arrive.
- R10: A synchronous active-high `rst` clears all registers, `flags_o` and `illegal_o` to zero.
- R11: `dbg_rdata` shows register `dbg_sel` combinationally. The write from an instruction becomes visible after the clock edge that executes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word valid this cycle |
| instr_word | input | 32 | Instruction word |
| dbg_sel | input | 4 | Debug read register index |
| dbg_rdata | output | 32 | Debug read data |
| flags_o | output | 5 | Status flags (untouched by these instructions) |
| illegal_o | output | 1 | One-cycle pulse for an unrecognised instruction |

## Verification
The bench builds the unit with its default widths: 32-bit registers, a 9-bit immediate and five flags. At these widths, the extreme integers 0x80000000 and 0x7FFFFFFF reach the places where signed and unsigned order disagree. An immediate of 0x1FF reaches the point where sign extension and zero extension split into -1 and 511. With sixteen registers, one register can stay at zero while others are filled bit by bit through the instruction path alone. That path also exercises the case where the destination is an operand and the case where bit 31 is shifted out.

// File: rtl/cmp_shift_unit.sv
module cmp_shift_unit #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 9,
  parameter int NREGS  = 16,
  parameter int NFLAGS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic [3:0]        dbg_sel,
  output logic [XLEN-1:0]   dbg_rdata,
  output logic [NFLAGS-1:0] flags_o,
  output logic              illegal_o
);

  localparam logic [7:0] OP_IMM  = 8'h8B;
  localparam logic [7:0] OP_REG  = 8'h0B;
  localparam logic [7:0] SUB_SGN = 8'h39;
  localparam logic [7:0] SUB_UNS = 8'h3A;

  logic [XLEN-1:0] regs [NREGS];

  logic       fmt_imm, fmt_reg;
  logic       imm_s, imm_u, reg_s, reg_u;
  logic       legal, uns;
  logic [3:0] idx_a, idx_b, idx_d;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  imm_ext, opa, opb;
  logic             lt_bit;

  assign fmt_imm = instr_word[7:0] == OP_IMM;
  assign fmt_reg = instr_word[7:0] == OP_REG;
  assign imm_s   = fmt_imm && instr_word[27:21] == SUB_SGN[6:0];
  assign imm_u   = fmt_imm && instr_word[27:21] == SUB_UNS[6:0];
  assign reg_s   = fmt_reg && instr_word[27:20] == SUB_SGN;
  assign reg_u   = fmt_reg && instr_word[27:20] == SUB_UNS;
  assign legal   = imm_s | imm_u | reg_s | reg_u;
  assign uns     = imm_u | reg_u;

  assign idx_a = instr_word[11:8];
  assign idx_b = instr_word[15:12];
  assign idx_d = instr_word[31:28];
  assign imm   = instr_word[20:12];

  assign imm_ext = uns ? {{(XLEN-IMM_W){1'b0}}, imm}
                       : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign opa     = regs[idx_a];
  assign opb     = fmt_imm ? imm_ext : regs[idx_b];
  assign lt_bit  = uns ? (opa < opb) : ($signed(opa) < $signed(opb));

  assign dbg_rdata = regs[dbg_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      illegal_o <= 1'b0;
    end else begin
      illegal_o <= instr_valid && !legal;
      if (instr_valid && legal)
        regs[idx_d] <= {regs[idx_d][XLEN-2:0], lt_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
  end

endmodule

// File: rtl/cmp_shift_unit_chk.sv
module cmp_shift_unit_chk #(
  parameter int NFLAGS = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic [31:0]       instr_word,
  input logic [NFLAGS-1:0] flags_o,
  input logic              illegal_o
);

  AST_FLAGS_STABLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(flags_o)) else $error("flags changed"); // R9

  AST_ILLEGAL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> $past(instr_valid)) else $error("illegal without valid"); // R7

  AST_IDLE_NO_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !illegal_o) else $error("illegal while idle"); // R8

  AST_BAD_PRIMARY: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_word[7:0] != 8'h8B && instr_word[7:0] != 8'h0B) |=> illegal_o)
    else $error("bad primary opcode not flagged"); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!illegal_o && flags_o == '0)) else $error("reset state wrong"); // R10

endmodule

bind cmp_shift_unit cmp_shift_unit_chk #(.NFLAGS(NFLAGS)) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
  .flags_o(flags_o), .illegal_o(illegal_o)
);

// File: tb/cmp_shift_unit_tb.sv
module cmp_shift_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [3:0]  dbg_sel = '0;
  logic [31:0] dbg_rdata;
  logic [4:0]  flags_o;
  logic        illegal_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmp_shift_unit u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .dbg_sel(dbg_sel), .dbg_rdata(dbg_rdata), .flags_o(flags_o), .illegal_o(illegal_o)
  );

  localparam logic [7:0] SG = 8'h39;
  localparam logic [7:0] US = 8'h3A;

  function automatic logic [31:0] enc_imm(logic [7:0] sub, logic [3:0] d, logic [3:0] a, logic [8:0] k);
    return {d, sub[6:0], k, a, 8'h8B};
  endfunction

  function automatic logic [31:0] enc_reg(logic [7:0] sub, logic [3:0] d, logic [3:0] a, logic [3:0] b);
    return {d, sub, 4'h0, b, a, 8'h0B};
  endfunction

  // {instruction, expected compare bit}; registers preloaded: r1=-1, r2=5, r3=0x80000000, r4=0x7FFFFFFF, r15=0
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {enc_reg(SG, 4'd8, 4'd1, 4'd2), 1'b1},   // R2 -1 < 5
    {enc_reg(US, 4'd8, 4'd1, 4'd2), 1'b0},   // R3 max unsigned not < 5
    {enc_reg(SG, 4'd8, 4'd3, 4'd4), 1'b1},   // R2 min < max
    {enc_reg(US, 4'd8, 4'd4, 4'd3), 1'b1},   // R3 0x7FFFFFFF < 0x80000000
    {enc_reg(US, 4'd8, 4'd3, 4'd4), 1'b0},   // R3
    {enc_imm(SG, 4'd8, 4'd2, 9'h1FF), 1'b0}, // R4 5 < -1 false
    {enc_imm(US, 4'd8, 4'd2, 9'h1FF), 1'b1}, // R4 5 < 511
    {enc_imm(SG, 4'd8, 4'd1, 9'h000), 1'b1}, // R4 -1 < 0
    {enc_imm(US, 4'd8, 4'd1, 9'h000), 1'b0}, // R3
    {enc_imm(SG, 4'd8, 4'd2, 9'h005), 1'b0}, // R2 equal gives 0
    {enc_imm(SG, 4'd8, 4'd2, 9'h006), 1'b1}, // R2
    {enc_imm(US, 4'd2, 4'd2, 9'h006), 1'b1}  // R6 destination is operand: old 5 < 6
  };

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic load_reg(logic [3:0] r, logic [31:0] v);
    for (int i = 31; i >= 0; i--)
      issue(enc_imm(US, r, 4'd15, {8'h00, v[i]}));
  endtask

  task automatic read_reg(logic [3:0] r, output logic [31:0] v);
    dbg_sel = r;
    #0.5;
    v = dbg_rdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] old, now;
    logic [31:0] r8_save;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    for (int r = 0; r < 16; r++) begin
      read_reg(r[3:0], now);
      check(now == 0, "R10 register cleared", now, 0);
    end
    check(flags_o == 0, "R10 flags cleared", {27'd0, flags_o}, 0);
    check(illegal_o == 0, "R10 illegal low", {31'd0, illegal_o}, 0);

    load_reg(4'd1, 32'hFFFF_FFFF);
    load_reg(4'd2, 32'd5);
    load_reg(4'd3, 32'h8000_0000);
    load_reg(4'd4, 32'h7FFF_FFFF);
    read_reg(4'd3, now);
    check(now == 32'h8000_0000, "R1 R11 loaded via shifts", now, 32'h8000_0000);

    for (int i = 0; i < NV; i++) begin
      read_reg(VEC[i][32:29], old);
      issue(VEC[i][32:1]);
      read_reg(VEC[i][32:29], now);
      check(now == {old[30:0], VEC[i][0]}, $sformatf("R1 R2 R3 R4 R6 vector %0d", i),
            now, {old[30:0], VEC[i][0]});
    end

    // R1 bit 31 is discarded: r3 = 0x80000000 shifted with 0
    issue(enc_imm(US, 4'd3, 4'd15, 9'h000));
    read_reg(4'd3, now);
    check(now == 0, "R1 bit 31 dropped", now, 0);

    // R5 unused bits 19:16 ignored in register format
    read_reg(4'd9, old);
    issue(enc_reg(SG, 4'd9, 4'd1, 4'd2) | 32'h000F_0000);
    read_reg(4'd9, now);
    check(now == {old[30:0], 1'b1}, "R5 unused bits ignored", now, {old[30:0], 1'b1});

    // R7 illegal encodings: wrong primary, wrong secondary, register secondary in immediate form mismatch
    read_reg(4'd8, r8_save);
    issue(enc_imm(SG, 4'd8, 4'd1, 9'h000) & 32'hFFFF_FF00 | 32'h0000_008C);
    check(illegal_o == 1, "R7 illegal pulse primary", {31'd0, illegal_o}, 1);
    issue(enc_reg(8'h3B, 4'd8, 4'd1, 4'd2));
    check(illegal_o == 1, "R7 illegal pulse secondary", {31'd0, illegal_o}, 1);
    issue(enc_reg(8'hB9, 4'd8, 4'd1, 4'd2));
    check(illegal_o == 1, "R5 R7 8-bit secondary checked", {31'd0, illegal_o}, 1);
    @(negedge clk);
    check(illegal_o == 0, "R7 pulse lasts one cycle", {31'd0, illegal_o}, 0);
    read_reg(4'd8, now);
    check(now == r8_save, "R7 register unchanged", now, r8_save);

    // R8 valid low: legal word presented without valid
    instr_word = enc_imm(US, 4'd8, 4'd15, 9'h001);
    repeat (3) @(negedge clk);
    read_reg(4'd8, now);
    check(now == r8_save, "R8 no change while idle", now, r8_save);
    check(illegal_o == 0, "R8 illegal low while idle", {31'd0, illegal_o}, 0);

    // R9 flags untouched after all instructions
    check(flags_o == 0, "R9 flags unchanged", {27'd0, flags_o}, 0);

    // R10 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    read_reg(4'd8, now);
    check(now == 0, "R10 reset clears r8", now, 0);
    read_reg(4'd4, now);
    check(now == 0, "R10 reset clears r4", now, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule